// File: doc/BRIEF.md
# Three-State Power Mode Controller

This controller decides how a battery-backed metering chip is powered. It runs in one of three steady modes. In normal mode the chip runs from the main supply with everything on. In battery mode the chip runs from the battery, the core stays on and the analog measurement front end is off. In sleep mode the chip runs from the battery with the core domain off. A fourth, transient wake state holds the core in reset for a fixed number of cycles. The controller enters this state after power-on and after every exit from sleep, so the core always restarts from its reset vector.

The controller drives the supply-source select, the core and analog domain enables, the core reset, a core clock-rate code and the enables of the always-on peripherals. It also holds a small register bank, reached through a plain 8-bit address/data port. Eight of these registers keep their contents across sleep: four scratch registers and four configuration registers. A volatile clock register returns to its default every time the core is reset. Mode inputs are a main-supply-good flag, a software power-down bit, a sleep request and a wake event.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: In normal mode (`pwr_mode` = 0), `supply_sel` = 0 (main supply), `core_en` = 1, `afe_en` = 1 and `core_rst` = 0.
- R2: In normal mode, a clock edge that samples `main_ok` = 0 puts the controller in battery mode (`pwr_mode` = 1) in the next cycle, with `supply_sel` = 1, `core_en` = 1 and `afe_en` = 0.
- R3: Battery mode returns to normal mode only on an edge where `main_ok` = 1 and `sw_pwrdn` = 0. If either condition fails, the controller stays in battery mode.
- R4: `sleep_req` is accepted in normal or battery mode. The next cycle is then sleep (`pwr_mode` = 2), with `supply_sel` = 1, `core_en` = 0, `afe_en` = 0 and `core_rst` = 0. In battery mode a sleep request wins over a return to normal. In normal mode a loss of `main_ok` wins over a sleep request.
- R5: Sleep is left only on `wake_evt`. Changes on `main_ok`, `sw_pwrdn` and `sleep_req` have no effect while asleep.
- R6: A `wake_evt` in sleep, or the release of `rst_n`, enters the wake state (`pwr_mode` = 3). In that state `core_rst` = 1 and `core_en` = 1 for exactly 16 cycles. The controller then enters normal mode if `main_ok` = 1, or battery mode otherwise.
- R7: Addresses 0x00 to 0x03 are four 8-bit scratch registers. They can be written and read, and they keep their values through sleep and wake.
- R8: Addresses 0x04 to 0x07 are retained 8-bit configuration registers. Bits [2:0] of address 0x07 drive `periph_en` (bit 0 temperature/supply measurement, bit 1 real-time clock, bit 2 display) in every mode, including sleep.
- R9: Bits [2:0] of address 0x08 drive `clk_sel`, and its upper bits read as 0. Its value after any reset and after every wake is 3'b010, the 1.024 MHz code.
- R10: While the core is inactive (sleep or wake state), writes are ignored and `reg_rdata` reads 0. Addresses above 0x08 ignore writes and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| main_ok | input | 1 | Main supply above switchover threshold |
| sw_pwrdn | input | 1 | Software power-down bit; blocks return to normal |
| sleep_req | input | 1 | Software sleep request |
| wake_evt | input | 1 | Wake event pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on address) |
| pwr_mode | output | 2 | 0 normal, 1 battery, 2 sleep, 3 wake |
| supply_sel | output | 1 | 0 main supply, 1 battery |
| core_en | output | 1 | Core/digital domain enable |
| afe_en | output | 1 | Analog front-end domain enable |
| core_rst | output | 1 | Core reset, active high |
| clk_sel | output | 3 | Core clock-rate code |
| periph_en | output | 3 | Always-on peripheral enables |

## Verification
The assertions assume that `rst_n` is asserted before the first clock edge. They also assume that all inputs change only away from the rising edge, so each input has one value per cycle. The register-port checks assume that a write lasts exactly one cycle and that the address is steady while `reg_rdata` is read. The stimulus drives every input on the falling edge, holds `reg_we` high for a single cycle, and pulses `wake_evt` for one cycle. It also makes competing requests arrive in the same cycle, so that each priority is tested.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int PMC_DW        = 8;
  localparam int PMC_AW        = 8;
  localparam int PMC_N_SCRATCH = 4;
  localparam int PMC_N_CFG     = 4;
  localparam int PMC_N_PERIPH  = 3;
  localparam int PMC_CLK_W     = 3;
  localparam int PMC_HOLD      = 16;

  typedef enum logic [1:0] {
    PM_NORMAL  = 2'd0,
    PM_BATTERY = 2'd1,
    PM_SLEEP   = 2'd2,
    PM_WAKE    = 2'd3
  } pmc_mode_e;
endpackage

// File: rtl/pmc_seq.sv
module pmc_seq
  import pmc_pkg::*;
#(
  parameter int HOLD_CYCLES = PMC_HOLD
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      main_ok,
  input  logic      sw_pwrdn,
  input  logic      sleep_req,
  input  logic      wake_evt,
  output pmc_mode_e mode
);
  localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  pmc_mode_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PM_NORMAL: begin
        if (!main_ok)       state_d = PM_BATTERY;
        else if (sleep_req) state_d = PM_SLEEP;
      end
      PM_BATTERY: begin
        if (sleep_req)                 state_d = PM_SLEEP;
        else if (main_ok && !sw_pwrdn) state_d = PM_NORMAL;
      end
      PM_SLEEP: begin
        if (wake_evt) state_d = PM_WAKE;
      end
      PM_WAKE: begin
        if (cnt_q == LAST) state_d = main_ok ? PM_NORMAL : PM_BATTERY;
      end
      default: state_d = PM_WAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_WAKE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == PM_WAKE && state_d == PM_WAKE) cnt_q <= cnt_q + 1'b1;
      else                                          cnt_q <= '0;
    end
  end

  assign mode = state_q;

  AST_SUPPLY_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_NORMAL && !main_ok) |=> (state_q == PM_BATTERY)); // R2
  AST_BATT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_BATTERY && !sleep_req && (!main_ok || sw_pwrdn)) |=> (state_q == PM_BATTERY)); // R3
  AST_SLEEP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_SLEEP && !wake_evt) |=> (state_q == PM_SLEEP)); // R5
  AST_SLEEP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_SLEEP && wake_evt) |=> (state_q == PM_WAKE && cnt_q == '0)); // R6
  AST_WAKE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PM_WAKE) |-> (cnt_q == '0)); // R6
endmodule

// File: rtl/pmc_domain_map.sv
module pmc_domain_map
  import pmc_pkg::*;
(
  input  pmc_mode_e mode,
  output logic      supply_sel,
  output logic      core_en,
  output logic      afe_en,
  output logic      core_rst
);
  always_comb begin
    supply_sel = 1'b1;
    core_en    = 1'b0;
    afe_en     = 1'b0;
    core_rst   = 1'b0;
    unique case (mode)
      PM_NORMAL: begin
        supply_sel = 1'b0;
        core_en    = 1'b1;
        afe_en     = 1'b1;
      end
      PM_BATTERY: core_en = 1'b1;
      PM_SLEEP:   ;
      PM_WAKE: begin
        core_en  = 1'b1;
        core_rst = 1'b1;
      end
      default: core_rst = 1'b1;
    endcase
  end
endmodule

// File: rtl/pmc_regbank.sv
module pmc_regbank
  import pmc_pkg::*;
#(
  parameter int DW          = PMC_DW,
  parameter int AW          = PMC_AW,
  parameter int N_SCRATCH   = PMC_N_SCRATCH,
  parameter int N_CFG       = PMC_N_CFG,
  parameter int N_PERIPH    = PMC_N_PERIPH,
  parameter int CLK_W       = PMC_CLK_W,
  parameter logic [CLK_W-1:0] CLK_DEFAULT = CLK_W'(2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                core_active,
  input  logic                vol_clr,
  input  logic                we,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rdata,
  output logic [CLK_W-1:0]    clk_sel,
  output logic [N_PERIPH-1:0] periph_en
);
  localparam int N_RET      = N_SCRATCH + N_CFG;
  localparam int IDX_PERIPH = N_RET - 1;
  localparam int ADDR_CLK   = N_RET;

  logic [N_RET-1:0][DW-1:0] ret_q;
  logic [CLK_W-1:0]         clk_q;
  logic                     wr_ok;

  assign wr_ok = we && core_active;

  for (genvar i = 0; i < N_RET; i++) begin : g_ret
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               ret_q[i] <= '0;
      else if (wr_ok && addr == AW'(i))         ret_q[i] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               clk_q <= CLK_DEFAULT;
    else if (vol_clr)                         clk_q <= CLK_DEFAULT;
    else if (wr_ok && addr == AW'(ADDR_CLK))  clk_q <= wdata[CLK_W-1:0];
  end

  always_comb begin
    rdata = '0;
    if (core_active) begin
      if (addr < AW'(N_RET))           rdata = ret_q[addr[$clog2(N_RET)-1:0]];
      else if (addr == AW'(ADDR_CLK))  rdata = DW'(clk_q);
    end
  end

  assign clk_sel   = clk_q;
  assign periph_en = ret_q[IDX_PERIPH][N_PERIPH-1:0];

  AST_NO_WRITE_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !core_active |=> $stable(ret_q)); // R10
  AST_CLK_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    vol_clr |=> (clk_q == CLK_DEFAULT)); // R9
  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !core_active |-> (rdata == '0)); // R10
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int HOLD_CYCLES = PMC_HOLD
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    main_ok,
  input  logic                    sw_pwrdn,
  input  logic                    sleep_req,
  input  logic                    wake_evt,
  input  logic                    reg_we,
  input  logic [PMC_AW-1:0]       reg_addr,
  input  logic [PMC_DW-1:0]       reg_wdata,
  output logic [PMC_DW-1:0]       reg_rdata,
  output logic [1:0]              pwr_mode,
  output logic                    supply_sel,
  output logic                    core_en,
  output logic                    afe_en,
  output logic                    core_rst,
  output logic [PMC_CLK_W-1:0]    clk_sel,
  output logic [PMC_N_PERIPH-1:0] periph_en
);
  pmc_mode_e mode;
  logic      core_active;

  pmc_seq #(.HOLD_CYCLES(HOLD_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .main_ok   (main_ok),
    .sw_pwrdn  (sw_pwrdn),
    .sleep_req (sleep_req),
    .wake_evt  (wake_evt),
    .mode      (mode)
  );

  pmc_domain_map u_map (
    .mode       (mode),
    .supply_sel (supply_sel),
    .core_en    (core_en),
    .afe_en     (afe_en),
    .core_rst   (core_rst)
  );

  assign core_active = core_en && !core_rst;

  pmc_regbank u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_active (core_active),
    .vol_clr     (core_rst),
    .we          (reg_we),
    .addr        (reg_addr),
    .wdata       (reg_wdata),
    .rdata       (reg_rdata),
    .clk_sel     (clk_sel),
    .periph_en   (periph_en)
  );

  assign pwr_mode = mode;

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == PM_NORMAL || mode == PM_BATTERY) && main_ok && sleep_req) |=> !core_en); // R4
  AST_AFE_MAIN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (afe_en && !main_ok) |=> !afe_en); // R2
endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       main_ok = 1'b1, sw_pwrdn = 1'b0, sleep_req = 1'b0, wake_evt = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] pwr_mode;
  logic       supply_sel, core_en, afe_en, core_rst;
  logic [2:0] clk_sel, periph_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pwr_mode_ctrl u_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .main_ok(main_ok), .sw_pwrdn(sw_pwrdn),
    .sleep_req(sleep_req), .wake_evt(wake_evt), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pwr_mode(pwr_mode), .supply_sel(supply_sel), .core_en(core_en),
    .afe_en(afe_en), .core_rst(core_rst), .clk_sel(clk_sel), .periph_en(periph_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // pwr_mode, supply_sel, core_en, afe_en, core_rst packed as one value
  function automatic int pack_out();
    return {pwr_mode, supply_sel, core_en, afe_en, core_rst};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic count_rst(input string req, input logic exp_main);
    int n = 0;
    while (core_rst && n < 100) begin
      if (!core_en) chk({req, " core_en in wake"}, 0, 1);
      n++;
      step();
    end
    chk({req, " reset length"}, n, 16);
    chk({req, " mode after wake"}, pwr_mode, exp_main ? 0 : 1);
  endtask

  task automatic t_power_on();
    chk("R6 reset outputs", pack_out(), {2'd3, 1'b1, 1'b1, 1'b0, 1'b1});
    chk("R9 clk default at reset", clk_sel, 3'b010);
    rd_chk("R10 rdata in reset", 8'h00, 8'h00);
    rst_n = 1'b1;
    count_rst("R6 power-on", 1'b1);
  endtask

  task automatic t_normal();
    chk("R1 normal outputs", pack_out(), {2'd0, 1'b0, 1'b1, 1'b1, 1'b0});
  endtask

  task automatic t_supply_loss();
    main_ok = 1'b0;
    step();
    chk("R2 battery after loss", pack_out(), {2'd1, 1'b1, 1'b1, 1'b0, 1'b0});
  endtask

  task automatic t_battery_return();
    main_ok = 1'b1; sw_pwrdn = 1'b1;
    repeat (3) step();
    chk("R3 held by pwrdn", pwr_mode, 1);
    main_ok = 1'b0; sw_pwrdn = 1'b0;
    repeat (2) step();
    chk("R3 held by no supply", pwr_mode, 1);
    main_ok = 1'b1;
    step();
    chk("R3 return to normal", pack_out(), {2'd0, 1'b0, 1'b1, 1'b1, 1'b0});
  endtask

  task automatic t_registers();
    for (int i = 0; i < 8; i++) wr(8'(i), 8'(8'h30 + 8'(i * 17)));
    wr(8'h08, 8'hFD);
    wr(8'h20, 8'h77);
    for (int i = 0; i < 4; i++) rd_chk("R7 scratch readback", 8'(i), 8'(8'h30 + 8'(i * 17)));
    for (int i = 4; i < 8; i++) rd_chk("R8 config readback", 8'(i), 8'(8'h30 + 8'(i * 17)));
    chk("R8 periph_en from cfg", periph_en, 3'(8'h30 + 8'(7 * 17)));
    chk("R9 clk_sel written", clk_sel, 3'b101);
    rd_chk("R9 clk reg upper bits", 8'h08, 8'h05);
    rd_chk("R10 unmapped reads 0", 8'h20, 8'h00);
  endtask

  task automatic t_sleep_priority();
    main_ok = 1'b0;
    step();
    chk("R2 battery before sleep", pwr_mode, 1);
    main_ok = 1'b1; sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    chk("R4 sleep wins over return", pack_out(), {2'd2, 1'b1, 1'b0, 1'b0, 1'b0});
  endtask

  task automatic t_sleep_hold();
    wr(8'h00, 8'hEE);
    main_ok = 1'b0; sleep_req = 1'b1; sw_pwrdn = 1'b1;
    repeat (3) step();
    main_ok = 1'b1; sleep_req = 1'b0; sw_pwrdn = 1'b0;
    repeat (3) step();
    chk("R5 still asleep", pack_out(), {2'd2, 1'b1, 1'b0, 1'b0, 1'b0});
    chk("R8 periph_en in sleep", periph_en, 3'(8'h30 + 8'(7 * 17)));
    rd_chk("R10 rdata asleep", 8'h01, 8'h00);
  endtask

  task automatic t_wake(input logic supply);
    main_ok = supply;
    wake_evt = 1'b1;
    step();
    wake_evt = 1'b0;
    chk("R6 wake state entered", pwr_mode, 3);
    count_rst("R6 wake", supply);
  endtask

  task automatic t_after_wake();
    chk("R9 clk default after wake", clk_sel, 3'b010);
    rd_chk("R10 sleep write ignored", 8'h00, 8'h30);
    for (int i = 1; i < 4; i++) rd_chk("R7 scratch retained", 8'(i), 8'(8'h30 + 8'(i * 17)));
    for (int i = 4; i < 8; i++) rd_chk("R8 config retained", 8'(i), 8'(8'h30 + 8'(i * 17)));
  endtask

  task automatic t_loss_beats_sleep();
    main_ok = 1'b1;
    step();
    chk("R3 normal again", pwr_mode, 0);
    main_ok = 1'b0; sleep_req = 1'b1;
    step();
    chk("R4 loss wins over sleep", pwr_mode, 1);
    step();
    sleep_req = 1'b0;
    chk("R4 sleep from battery", pwr_mode, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_power_on();
    t_normal();
    t_supply_loss();
    t_battery_return();
    t_registers();
    t_sleep_priority();
    t_sleep_hold();
    t_wake(1'b0);
    t_after_wake();
    t_loss_beats_sleep();
    t_wake(1'b1);
    t_normal();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule